// File: doc/BRIEF.md
# SPI Character Display Sequencer

This block brings up a three-line character display controller over a write-only serial link, then sends text strings to it. After reset it keeps the display deselected for a long power-up interval. It then issues a fixed series of ten setup commands, one per chip-select window. Each command is followed by a settling pause, and two of the commands get a much longer pause. The contrast level is a parameter and goes into the low nibble of one of those commands.

Once setup is finished, the host writes characters into an internal byte buffer and presents a length. A start pulse then streams the buffered bytes, beginning at address 0, inside a single chip-select window. A length above the configured maximum is clipped to that maximum. The host follows progress through `busy_o` and a one-cycle `done_o` pulse. A register-select line tells the display whether a byte is a command or character data.

Top module: `lcd_spi_seq`

## Requirements
- R1: After reset release `cs_no` stays high, and it first falls at the PWRUP_CYC-th rising clock edge. While `cs_no` is high, `sclk_o` stays high.
- R2: The setup bytes go out in this order, each with `rs_o` low: 0x39, 0x1D, 0x50, 0x6C, {0x7, CONTRAST}, 0x38, 0x0F, 0x01, 0x02, 0x06. With the default contrast of 6 the fifth byte is 0x76.
- R3: Every setup byte has its own chip-select window. After a byte, `cs_no` stays high for at least LONG_CYC cycles when the byte was the follower command (0x38, sixth) or the clear command (0x01, eighth). After any other byte it stays high for at least SHORT_CYC cycles.
- R4: The link runs in SPI mode 3, most significant bit first. `mosi_o` is valid on each rising edge of `sclk_o` and changes only while `sclk_o` is low.
- R5: Each low half and each high half of a bit on `sclk_o` lasts at least HALF_CYC clock cycles.
- R6: `busy_o` is high from reset until setup completes and `init_done_o` rises. `init_done_o` then stays high. `busy_o` is also high in the cycle after an accepted start.
- R7: A string is sent in one chip-select window with `rs_o` high. Its bytes come from buffer addresses 0, 1, 2, … in order, and `rs_o` does not change inside the window.
- R8: The number of bytes sent is the smaller of `len_i` and MAX_LEN.
- R9: A `start_i` pulse while `busy_o` is high is ignored. No further window opens and no further bytes are sent.
- R10: `done_o` is a single-cycle pulse. While it is high, `busy_o` is low and `cs_no` is high.
- R11: A start with length 0 gives a `done_o` pulse and does not assert `cs_no`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the character buffer |
| wr_addr_i | input | AW | Buffer write address |
| wr_data_i | input | 8 | Buffer write byte |
| len_i | input | AW+1 | String length, sampled together with start |
| start_i | input | 1 | Start request for a string transfer |
| busy_o | output | 1 | Setup or transfer in progress |
| done_o | output | 1 | One-cycle pulse when a string transfer ends |
| init_done_o | output | 1 | Setup sequence complete |
| cs_no | output | 1 | Display chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data to the display |
| rs_o | output | 1 | Register select: 0 command, 1 character data |

## Verification
`busy_o` is checked at the first falling clock edge after the rising edge that accepts `start_i`. `done_o` is checked at the falling edge where it first appears. The bench waits for that edge, then checks that the pulse has gone one cycle later. The first fall of chip select is expected exactly PWRUP_CYC rising edges after reset release. Serial bytes, window numbers and high-time gaps are recorded by a monitor that samples every falling clock edge and rebuilds each byte on the rising edges of `sclk_o`. Because of this, the data checks depend only on the order of events and not on internal cycle offsets. The bench runs string lengths from 0 up to the full width of the length field, with a different buffer pattern for each length.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  localparam int unsigned INIT_LEN   = 10;
  localparam logic [3:0]  IDX_FOLLOW = 4'd5;
  localparam logic [3:0]  IDX_CLEAR  = 4'd7;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_CMD_SEND,
    ST_CMD_WAIT,
    ST_IDLE,
    ST_STR_SEND,
    ST_STR_TAIL
  } seq_state_e;

  function automatic logic [7:0] init_cmd(input logic [3:0] idx, input logic [3:0] contrast);
    case (idx)
      4'd0:    return 8'h39;
      4'd1:    return 8'h1D;
      4'd2:    return 8'h50;
      4'd3:    return 8'h6C;
      4'd4:    return {4'h7, contrast};
      4'd5:    return 8'h38;
      4'd6:    return 8'h0F;
      4'd7:    return 8'h01;
      4'd8:    return 8'h02;
      default: return 8'h06;
    endcase
  endfunction

endpackage

// File: rtl/lcd_spi_shift.sv
module lcd_spi_shift #(
  parameter int unsigned HALF_CYC = 63,
  localparam int unsigned DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] byte_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       fin_o
);

  logic             active_q;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q;
  logic             tick;

  assign tick   = (div_q == DIV_W'(HALF_CYC - 1));
  assign mosi_o = sh_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      sclk_o   <= 1'b1;
      fin_o    <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (!active_q) begin
        if (go_i) begin
          active_q <= 1'b1;
          sh_q     <= byte_i;
          bit_q    <= 3'd7;
          div_q    <= '0;
          sclk_o   <= 1'b0;
        end
      end else if (!tick) begin
        div_q <= div_q + 1'b1;
      end else begin
        div_q <= '0;
        if (!sclk_o) begin
          sclk_o <= 1'b1;
        end else if (bit_q == 3'd0) begin
          active_q <= 1'b0;
          fin_o    <= 1'b1;
        end else begin
          // next bit is set up on the falling edge
          bit_q  <= bit_q - 1'b1;
          sh_q   <= {sh_q[6:0], 1'b0};
          sclk_o <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/lcd_char_buf.sv
module lcd_char_buf #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl import lcd_seq_pkg::*; #(
  parameter int unsigned PWRUP_CYC = 21000000,
  parameter int unsigned SHORT_CYC = 1600,
  parameter int unsigned LONG_CYC  = 105000,
  parameter int unsigned MAX_LEN   = 32,
  parameter int unsigned AW        = 5,
  parameter logic [3:0]  CONTRAST  = 4'h6,
  localparam int unsigned LEN_W    = AW + 1,
  localparam int unsigned WAIT_MAX = (PWRUP_CYC > LONG_CYC) ?
                                     ((PWRUP_CYC > SHORT_CYC) ? PWRUP_CYC : SHORT_CYC) :
                                     ((LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC),
  localparam int unsigned WAIT_W   = $clog2(WAIT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             spi_fin_i,
  input  logic [7:0]       rd_data_i,
  output logic [AW-1:0]    rd_addr_o,
  output logic             spi_go_o,
  output logic [7:0]       spi_byte_o,
  output logic             cs_no,
  output logic             rs_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             init_done_o
);

  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

  seq_state_e        state_q;
  logic [WAIT_W-1:0] wait_q;
  logic [WAIT_W-1:0] wait_lim;
  logic [3:0]        cmd_idx_q;
  logic [LEN_W-1:0]  byte_idx_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  eff_len;
  logic              str_phase;

  assign eff_len   = (len_i > MAX_L) ? MAX_L : len_i;
  assign wait_lim  = ((cmd_idx_q == IDX_FOLLOW) || (cmd_idx_q == IDX_CLEAR)) ?
                     WAIT_W'(LONG_CYC - 1) : WAIT_W'(SHORT_CYC - 1);
  assign str_phase = (state_q == ST_STR_SEND);
  assign spi_byte_o = str_phase ? rd_data_i : init_cmd(cmd_idx_q, CONTRAST);
  assign rd_addr_o = byte_idx_q[AW-1:0];
  assign busy_o    = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_PWRUP;
      wait_q      <= '0;
      cmd_idx_q   <= '0;
      byte_idx_q  <= '0;
      len_q       <= '0;
      cs_no       <= 1'b1;
      rs_o        <= 1'b0;
      spi_go_o    <= 1'b0;
      done_o      <= 1'b0;
      init_done_o <= 1'b0;
    end else begin
      spi_go_o <= 1'b0;
      done_o   <= 1'b0;
      case (state_q)
        ST_PWRUP: begin
          if (wait_q == WAIT_W'(PWRUP_CYC - 1)) begin
            wait_q   <= '0;
            cs_no    <= 1'b0;
            spi_go_o <= 1'b1;
            state_q  <= ST_CMD_SEND;
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        ST_CMD_SEND: begin
          if (spi_fin_i) begin
            cs_no   <= 1'b1;
            state_q <= ST_CMD_WAIT;
          end
        end
        ST_CMD_WAIT: begin
          if (wait_q == wait_lim) begin
            wait_q <= '0;
            if (cmd_idx_q == 4'(INIT_LEN - 1)) begin
              init_done_o <= 1'b1;
              state_q     <= ST_IDLE;
            end else begin
              cmd_idx_q <= cmd_idx_q + 1'b1;
              cs_no     <= 1'b0;
              spi_go_o  <= 1'b1;
              state_q   <= ST_CMD_SEND;
            end
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        ST_IDLE: begin
          if (start_i) begin
            if (eff_len == '0) begin
              state_q <= ST_STR_TAIL;
            end else begin
              len_q      <= eff_len;
              byte_idx_q <= '0;
              cs_no      <= 1'b0;
              rs_o       <= 1'b1;
              spi_go_o   <= 1'b1;
              state_q    <= ST_STR_SEND;
            end
          end
        end
        ST_STR_SEND: begin
          if (spi_fin_i) begin
            if (byte_idx_q == len_q - LEN_W'(1)) begin
              cs_no   <= 1'b1;
              state_q <= ST_STR_TAIL;
            end else begin
              byte_idx_q <= byte_idx_q + 1'b1;
              spi_go_o   <= 1'b1;
            end
          end
        end
        ST_STR_TAIL: begin
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_PWRUP;
      endcase
    end
  end

endmodule

// File: rtl/lcd_spi_seq.sv
module lcd_spi_seq #(
  parameter int unsigned HALF_CYC  = 63,
  parameter int unsigned PWRUP_CYC = 21000000,
  parameter int unsigned SHORT_CYC = 1600,
  parameter int unsigned LONG_CYC  = 105000,
  parameter int unsigned BUF_DEPTH = 32,
  parameter int unsigned MAX_LEN   = 32,
  parameter logic [3:0]  CONTRAST  = 4'h6,
  localparam int unsigned AW       = $clog2(BUF_DEPTH),
  localparam int unsigned LEN_W    = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             init_done_o,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             rs_o
);

  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          spi_go;
  logic [7:0]    spi_byte;
  logic          spi_fin;

  lcd_char_buf #(.DEPTH(BUF_DEPTH)) i_buf (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  lcd_seq_ctrl #(
    .PWRUP_CYC (PWRUP_CYC),
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC),
    .MAX_LEN   (MAX_LEN),
    .AW        (AW),
    .CONTRAST  (CONTRAST)
  ) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .len_i       (len_i),
    .spi_fin_i   (spi_fin),
    .rd_data_i   (rd_data),
    .rd_addr_o   (rd_addr),
    .spi_go_o    (spi_go),
    .spi_byte_o  (spi_byte),
    .cs_no       (cs_no),
    .rs_o        (rs_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .init_done_o (init_done_o)
  );

  lcd_spi_shift #(.HALF_CYC(HALF_CYC)) i_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (spi_go),
    .byte_i (spi_byte),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o),
    .fin_o  (spi_fin)
  );

endmodule

// File: rtl/lcd_spi_seq_chk.sv
module lcd_spi_seq_chk #(
  parameter int unsigned PWRUP_CYC = 21000000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic init_done_o,
  input logic cs_no,
  input logic sclk_o,
  input logic mosi_o,
  input logic rs_o
);

  logic [31:0] pwr_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwr_cnt <= '0;
    else if (pwr_cnt < PWRUP_CYC) pwr_cnt <= pwr_cnt + 1'b1;
  end

  AST_PWRUP_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_cnt < PWRUP_CYC) |-> cs_no); // R1
  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o); // R1
  AST_MOSI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o)); // R4
  AST_RS_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !$past(cs_no)) |-> $stable(rs_o)); // R7
  AST_BUSY_BEFORE_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> busy_o); // R6
  AST_INIT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o); // R6
  AST_START_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && cs_no)); // R10

endmodule

bind lcd_spi_seq lcd_spi_seq_chk #(.PWRUP_CYC(PWRUP_CYC)) i_lcd_spi_seq_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .init_done_o (init_done_o),
  .cs_no       (cs_no),
  .sclk_o      (sclk_o),
  .mosi_o      (mosi_o),
  .rs_o        (rs_o)
);

// File: tb/test_lcd_spi_seq.sv
module test_lcd_spi_seq;

  localparam int CLK_PERIOD = 10;
  localparam int HALF   = 2;
  localparam int PWRUP  = 60;
  localparam int SHORT  = 12;
  localparam int LONG   = 45;
  localparam int DEPTH  = 8;
  localparam int MAXL   = 6;
  localparam logic [3:0] CONTR = 4'h6;
  localparam int AW     = $clog2(DEPTH);
  localparam int LEN_W  = AW + 1;
  localparam int WDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [LEN_W-1:0] len_in = '0;
  logic start = 1'b0;
  logic busy, done, init_done, cs_n, sclk, mosi, rs;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_spi_seq #(
    .HALF_CYC(HALF), .PWRUP_CYC(PWRUP), .SHORT_CYC(SHORT), .LONG_CYC(LONG),
    .BUF_DEPTH(DEPTH), .MAX_LEN(MAXL), .CONTRAST(CONTR)
  ) i_lcd_spi_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .len_i(len_in), .start_i(start), .busy_o(busy),
    .done_o(done), .init_done_o(init_done), .cs_no(cs_n), .sclk_o(sclk),
    .mosi_o(mosi), .rs_o(rs)
  );

  // monitor state
  logic [7:0] byte_q[$];
  bit         rs_q[$];
  int         win_q[$];
  int         gap_q[$];
  int cyc = 0, win_cnt = 0, hi_run = 0, first_fall = -1;
  int nb = 0, lo_run = 0, hi_s_run = 0, min_lo = 1000, min_hi = 1000;
  bit seen_rise = 1'b0, prev_done = 1'b0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  logic [7:0] cur = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (prev_cs && !cs_n) begin
        win_cnt++;
        gap_q.push_back(hi_run);
        if (first_fall < 0) first_fall = cyc;
        nb = 0;
        seen_rise = 1'b0;
      end
      hi_run = cs_n ? hi_run + 1 : 0;
      if (!cs_n) begin
        if (!prev_sclk && sclk) begin
          if (lo_run < min_lo) min_lo = lo_run;
          seen_rise = 1'b1;
          hi_s_run = 0;
          cur = {cur[6:0], mosi};
          nb++;
          if (nb == 8) begin
            byte_q.push_back(cur); rs_q.push_back(rs); win_q.push_back(win_cnt); nb = 0;
          end
        end
        if (prev_sclk && !sclk) begin
          if (seen_rise && hi_s_run < min_hi) min_hi = hi_s_run;
          lo_run = 0;
        end
        if (sclk) hi_s_run++; else lo_run++;
      end
      if (done) begin
        chk(!busy && cs_n, "R10 done with busy low and cs high", {busy, cs_n}, 1);
        chk(!prev_done, "R10 done single cycle", prev_done, 0);
      end
      prev_done = done;
      prev_cs = cs_n;
      prev_sclk = sclk;
    end
  end

  function automatic logic [7:0] exp_init(input int i);
    case (i)
      0: return 8'h39; 1: return 8'h1D; 2: return 8'h50; 3: return 8'h6C;
      4: return {4'h7, CONTR}; 5: return 8'h38; 6: return 8'h0F; 7: return 8'h01;
      8: return 8'h02; default: return 8'h06;
    endcase
  endfunction

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed * 29 + i * 53 + 7) ^ 8'(i << 5);
  endfunction

  task automatic load(input int seed);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); wr_en = 1'b1; wr_addr = AW'(i); wr_data = pat(seed, i);
    end
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
  endtask

  task automatic run_str(input int len, input int seed);
    int base, w0, exp_n;
    load(seed);
    base = byte_q.size(); w0 = win_cnt;
    start = 1'b1; len_in = LEN_W'(len);
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R6 busy after start", busy, 1);
    wait_done();
    chk(done == 1'b1, "R10 done reached", done, 1);
    exp_n = (len > MAXL) ? MAXL : len;
    chk(byte_q.size() - base == exp_n, "R8 byte count clipped", byte_q.size() - base, exp_n);
    for (int i = 0; i < exp_n; i++) begin
      if (base + i < byte_q.size()) begin
        chk(byte_q[base+i] == pat(seed, i), "R7 string byte", byte_q[base+i], pat(seed, i));
        chk(rs_q[base+i] == 1'b1, "R7 rs high for data", rs_q[base+i], 1);
        chk(win_q[base+i] == w0 + 1, "R7 one window", win_q[base+i], w0 + 1);
      end
    end
    if (exp_n == 0) chk(win_cnt == w0, "R11 zero length no window", win_cnt - w0, 0);
    else chk(win_cnt == w0 + 1, "R7 single window", win_cnt - w0, 1);
    @(negedge clk);
    chk(done == 1'b0, "R10 done cleared", done, 0);
  endtask

  initial begin
    int t;
    int base, w0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b1, "R1 reset outputs idle", {cs_n, sclk}, 3);
    chk(busy == 1'b1 && init_done == 1'b0 && done == 1'b0, "R6 reset state",
        {busy, init_done, done}, 4);
    #(CLK_PERIOD/4) rst_n = 1'b1;
    repeat (5) @(negedge clk);
    start = 1'b1; len_in = 3;   // R9: ignored during setup
    @(negedge clk); start = 1'b0;
    t = 0;
    while (!init_done && t < 20000) begin @(negedge clk); t++; end
    chk(init_done == 1'b1, "R6 setup completes", init_done, 1);
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R6 idle after setup", busy, 0);
    chk(first_fall == PWRUP, "R1 first chip select fall", first_fall, PWRUP);
    chk(byte_q.size() == 10 && win_cnt == 10, "R9 only setup bytes sent", byte_q.size(), 10);
    for (int i = 0; i < 10 && i < byte_q.size(); i++) begin
      chk(byte_q[i] == exp_init(i), "R2 setup byte", byte_q[i], exp_init(i));
      chk(rs_q[i] == 1'b0, "R2 rs low for command", rs_q[i], 0);
      chk(win_q[i] == i + 1, "R3 own window per command", win_q[i], i + 1);
    end
    for (int i = 1; i < 10 && i < gap_q.size(); i++) begin
      int lim = (i - 1 == 5 || i - 1 == 7) ? LONG : SHORT;
      chk(gap_q[i] >= lim, "R3 settle gap", gap_q[i], lim);
    end
    for (int len = 0; len < (1 << LEN_W); len++) run_str(len, len + 3);
    chk(min_lo >= HALF && min_hi >= HALF, "R5 sclk half periods", min_lo < min_hi ? min_lo : min_hi, HALF);
    // R9: start pulses during a transfer are ignored
    load(99);
    base = byte_q.size(); w0 = win_cnt;
    start = 1'b1; len_in = 5;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1; len_in = 2;
    @(negedge clk); start = 1'b0;
    wait_done();
    repeat (100) @(negedge clk);
    chk(byte_q.size() - base == 5, "R9 busy start ignored bytes", byte_q.size() - base, 5);
    chk(win_cnt - w0 == 1 && busy == 1'b0, "R9 busy start ignored window", win_cnt - w0, 1);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R6 watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule